// File: doc/BRIEF.md
# Run-time associativity cache with way concatenation

This block is a read-only cache of four physical ways, each 64 lines of eight 32-bit words, for 8 KB in total. A small configuration register picks how those same ways are grouped at run time: as one four-way set, as two pairs chosen by one address bit, or as four separate direct-mapped banks chosen by two address bits. In every grouping the whole capacity remains usable, but each access compares only the ways its group holds. Any way can also be switched off, which removes it from lookups and refills and shrinks the usable capacity.

The processor side is a valid/ready request carrying a word address and a one-cycle response pulse that carries the data and a flag telling whether a refill was needed. On a miss the block streams one whole line, one word per beat, from a word-wide memory port. It writes the line into a victim way that is taken in round-robin order from the enabled ways of the access, then returns the requested word. The configuration is meant to be written once after reset. Each accepted write clears every line.

Word-address layout used throughout: bits [2:0] select the word in the line, bits [8:3] the set index, bits [10:9] are the way-select bits, and bits [29:9] form the stored tag.

Top module: `wcc_cache`

## Requirements
- R1: After reset the mode is four-way, no way is shut, every line is invalid, req_ready is high, resp_valid and mem_req are low, and the first access to any address reports resp_miss = 1.
- R2: With cfg_mode = 2'b11 (four-way), up to four lines that share a set index but differ in tag are all held at once and all hit afterwards.
- R3: With cfg_mode = 2'b00 (direct-mapped), address bits [10:9] name the only way used. Four lines that share an index and differ only in those bits all stay resident. Two lines that agree in bits [10:9] but differ above bit 10 displace each other.
- R4: With cfg_mode = 2'b01 or 2'b10 (two-way), address bit 9 picks ways {0,1} when 0 and ways {2,3} when 1. A third line mapped to the same pair evicts an older one, and lines of the other pair are untouched.
- R5: cfg_shut bit k = 1 disables way k. A disabled way never reports a hit and never receives a fill, so in four-way mode with cfg_shut = 4'b0011 only two lines per index stay resident.
- R6: When no way is enabled for an access, the requested word is still returned after a full line transfer, but nothing is kept, and a repeat of that access misses again.
- R7: A miss drives mem_req with mem_addr stepping through the eight words of the line in ascending order from the line base. Each address is held until mem_rvalid, and the response carries the memory word of the requested address. Later accesses to any word of that line hit and return memory data.
- R8: Each set keeps a round-robin pointer that starts at way 0 after reset or after a configuration write. The victim is the first enabled way at or above the pointer, wrapping around. After a fill the pointer moves to the way after the filled one, and hits leave it unchanged.
- R9: A configuration write accepted while idle invalidates every line. During the cycle that cfg_we is high, req_ready is low.
- R10: cfg_we while a request is in progress is ignored: the mode, the shut mask and the valid lines all stay as they were, and req_ready stays low while a refill runs.
- R11: resp_valid is a single-cycle pulse. A hit is answered in the second cycle after the accepting clock edge, one lookup cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe, taken only when idle |
| cfg_mode | input | 2 | Grouping: 11 four-way, 01/10 two-way, 00 direct-mapped |
| cfg_shut | input | 4 | Per-way disable mask, bit k = 1 turns way k off |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 30 | Word address of the read |
| resp_valid | output | 1 | One-cycle pulse: response data is valid |
| resp_data | output | 32 | Word read |
| resp_miss | output | 1 | 1 when the response needed a line transfer |
| mem_req | output | 1 | Line transfer in progress, mem_addr valid |
| mem_addr | output | 30 | Word address of the current beat |
| mem_rvalid | input | 1 | Memory returns the word at mem_addr |
| mem_rdata | input | 32 | Word returned by memory |

## Verification
The hardest state to reach from the ports is a particular round-robin pointer position next to a particular mix of valid lines in one set, because the pointer is never visible. The stimulus builds it with a counted run of misses into one index and then infers each eviction from which of the earlier addresses misses again. The same method is repeated per grouping and shut mask so that the wrap past disabled ways is reached. A configuration write is also raised from a parallel process while a line transfer runs, and the lines and mode that must survive it are then probed.

// File: rtl/wcc_pkg.sv
package wcc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOOK = 2'd1,
      ST_FILL = 2'd2
   } wcc_state_e;

   localparam logic [1:0] GRP_DIRECT = 2'b00;
   localparam logic [1:0] GRP_FOUR   = 2'b11;

endpackage

// File: rtl/wcc_way_enable.sv
module wcc_way_enable #(
   parameter int WAYS = 4
) (
   input  logic [1:0]      grp,
   input  logic [1:0]      sel,
   input  logic [WAYS-1:0] shut,
   output logic [WAYS-1:0] en
);
   import wcc_pkg::*;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic in_group;
      always_comb begin
         case (grp)
            GRP_FOUR:   in_group = 1'b1;
            GRP_DIRECT: in_group = (sel == 2'(w));
            default:    in_group = (sel[0] == ((w / 2) != 0));
         endcase
      end
      assign en[w] = in_group & ~shut[w];
   end

endmodule

// File: rtl/wcc_tag_store.sv
module wcc_tag_store #(
   parameter int WAYS  = 4,
   parameter int SETS  = 64,
   parameter int TAG_W = 21,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [IDX_W-1:0] idx,
   input  logic [TAG_W-1:0] tag,
   input  logic [WAYS-1:0]  en,
   input  logic             ins_we,
   input  logic [WAYS-1:0]  ins_way,
   output logic [WAYS-1:0]  hit_vec
);

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [SETS-1:0]  vld_q;
      logic [TAG_W-1:0] tag_q [SETS];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      vld_q      <= '0;
         else if (flush)                  vld_q      <= '0;
         else if (ins_we && ins_way[w])   vld_q[idx] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (ins_we && ins_way[w]) tag_q[idx] <= tag;
      end

      assign hit_vec[w] = en[w] & vld_q[idx] & (tag_q[idx] == tag);
   end

endmodule

// File: rtl/wcc_victim.sv
module wcc_victim #(
   parameter int WAYS = 4,
   parameter int SETS = 64,
   localparam int IDX_W = $clog2(SETS),
   localparam int PTR_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [IDX_W-1:0] idx,
   input  logic [WAYS-1:0]  en,
   input  logic             upd,
   input  logic [WAYS-1:0]  upd_way,
   output logic [WAYS-1:0]  vict,
   output logic             vict_any
);

   logic [PTR_W-1:0] ptr_q [SETS];
   logic [PTR_W-1:0] cand;
   logic [PTR_W-1:0] upd_bin;

   always_comb begin
      vict     = '0;
      vict_any = 1'b0;
      cand     = '0;
      for (int k = 0; k < WAYS; k++) begin
         cand = PTR_W'(ptr_q[idx] + PTR_W'(k));
         if (!vict_any && en[cand]) begin
            vict[cand] = 1'b1;
            vict_any   = 1'b1;
         end
      end
   end

   always_comb begin
      upd_bin = '0;
      for (int w = 0; w < WAYS; w++)
         if (upd_way[w]) upd_bin = PTR_W'(w);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || flush) begin
         for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
      end else if (upd) begin
         ptr_q[idx] <= PTR_W'(upd_bin + PTR_W'(1));
      end
   end

endmodule

// File: rtl/wcc_cache.sv
module wcc_cache #(
   parameter int ADDR_W     = 30,
   parameter int DATA_W     = 32,
   parameter int WAYS       = 4,
   parameter int SETS       = 64,
   parameter int LINE_WORDS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_mode,
   input  logic [WAYS-1:0]   cfg_shut,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              resp_valid,
   output logic [DATA_W-1:0] resp_data,
   output logic              resp_miss,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata
);
   import wcc_pkg::*;

   localparam int WOFF_W  = $clog2(LINE_WORDS);
   localparam int IDX_W   = $clog2(SETS);
   localparam int WAY_W   = $clog2(WAYS);
   localparam int SEL_LSB = WOFF_W + IDX_W;
   localparam int TAG_W   = ADDR_W - SEL_LSB;
   localparam int DA_W    = WAY_W + IDX_W + WOFF_W;
   localparam int DEPTH   = WAYS * SETS * LINE_WORDS;

   if (WAYS != 4) begin : g_ways_chk
      $error("wcc_cache: the grouping logic needs exactly four ways");
   end
   if ((SETS & (SETS - 1)) != 0 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_pow2_chk
      $error("wcc_cache: SETS and LINE_WORDS must be powers of two");
   end
   if (TAG_W < 2) begin : g_tag_chk
      $error("wcc_cache: address too narrow for index and way-select bits");
   end

   wcc_state_e         state_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [1:0]         grp_q;
   logic [WAYS-1:0]    shut_q;
   logic [WOFF_W-1:0]  cnt_q;
   logic [WAYS-1:0]    vict_q;
   logic [WAY_W-1:0]   vbin_q;
   logic               vany_q;
   logic [DATA_W-1:0]  data_q [DEPTH];

   logic [IDX_W-1:0]   lk_idx;
   logic [TAG_W-1:0]   lk_tag;
   logic [WOFF_W-1:0]  lk_word;
   logic [WAYS-1:0]    en_mask;
   logic [WAYS-1:0]    hit_vec;
   logic               hit;
   logic [WAY_W-1:0]   hit_bin;
   logic [WAYS-1:0]    vict;
   logic               vict_any;
   logic [WAY_W-1:0]   vict_bin;
   logic               flush;
   logic               accept;
   logic               beat;
   logic               last_beat;
   logic               ins_we;

   assign lk_idx  = addr_q[WOFF_W +: IDX_W];
   assign lk_tag  = addr_q[ADDR_W-1:SEL_LSB];
   assign lk_word = addr_q[WOFF_W-1:0];

   assign flush     = cfg_we && (state_q == ST_IDLE);
   assign req_ready = (state_q == ST_IDLE) && !cfg_we;
   assign accept    = req_valid && req_ready;
   assign mem_req   = (state_q == ST_FILL);
   assign mem_addr  = {addr_q[ADDR_W-1:WOFF_W], cnt_q};
   assign beat      = mem_req && mem_rvalid;
   assign last_beat = beat && (cnt_q == WOFF_W'(LINE_WORDS - 1));
   assign ins_we    = last_beat && vany_q;
   assign hit       = |hit_vec;

   wcc_way_enable #(.WAYS(WAYS)) u_en (
      .grp  (grp_q),
      .sel  (addr_q[SEL_LSB +: 2]),
      .shut (shut_q),
      .en   (en_mask)
   );

   wcc_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .idx     (lk_idx),
      .tag     (lk_tag),
      .en      (en_mask),
      .ins_we  (ins_we),
      .ins_way (vict_q),
      .hit_vec (hit_vec)
   );

   wcc_victim #(.WAYS(WAYS), .SETS(SETS)) u_vict (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .idx      (lk_idx),
      .en       (en_mask),
      .upd      (ins_we),
      .upd_way  (vict_q),
      .vict     (vict),
      .vict_any (vict_any)
   );

   always_comb begin
      hit_bin  = '0;
      vict_bin = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_bin  = WAY_W'(w);
         if (vict[w])    vict_bin = WAY_W'(w);
      end
   end

   always_ff @(posedge clk) begin
      if (beat && vany_q) data_q[DA_W'({vbin_q, lk_idx, cnt_q})] <= mem_rdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         addr_q     <= '0;
         grp_q      <= GRP_FOUR;
         shut_q     <= '0;
         cnt_q      <= '0;
         vict_q     <= '0;
         vbin_q     <= '0;
         vany_q     <= 1'b0;
         resp_valid <= 1'b0;
         resp_data  <= '0;
         resp_miss  <= 1'b0;
      end else begin
         resp_valid <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (flush) begin
                  grp_q  <= cfg_mode;
                  shut_q <= cfg_shut;
               end else if (accept) begin
                  addr_q  <= req_addr;
                  state_q <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               if (hit) begin
                  resp_valid <= 1'b1;
                  resp_miss  <= 1'b0;
                  resp_data  <= data_q[DA_W'({hit_bin, lk_idx, lk_word})];
                  state_q    <= ST_IDLE;
               end else begin
                  vict_q  <= vict;
                  vbin_q  <= vict_bin;
                  vany_q  <= vict_any;
                  cnt_q   <= '0;
                  state_q <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (beat) begin
                  cnt_q <= cnt_q + WOFF_W'(1);
                  if (cnt_q == lk_word) resp_data <= mem_rdata;
                  if (last_beat) begin
                     resp_valid <= 1'b1;
                     resp_miss  <= 1'b1;
                     state_q    <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/wcc_cache_chk.sv
module wcc_cache_chk #(
   parameter int ADDR_W = 30,
   parameter int WAYS   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              resp_valid,
   input logic              mem_req,
   input logic              mem_rvalid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [WAYS-1:0]   hit_vec,
   input logic [WAYS-1:0]   en_mask,
   input logic              ins_we,
   input logic [WAYS-1:0]   ins_way
);

   // R2
   hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R5
   off_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec & ~en_mask) == '0);

   // R5
   fill_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_we |-> ($countones(ins_way) == 1 && (ins_way & ~en_mask) == '0));

   // R7
   beat_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> $stable(mem_addr));

   // R10
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);

   // R11
   resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

endmodule

bind wcc_cache wcc_cache_chk #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .resp_valid (resp_valid),
   .mem_req    (mem_req),
   .mem_rvalid (mem_rvalid),
   .mem_addr   (mem_addr),
   .hit_vec    (hit_vec),
   .en_mask    (en_mask),
   .ins_we     (ins_we),
   .ins_way    (vict_q)
);

// File: tb/wcc_cache_test.sv
module wcc_cache_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_mode = 2'b11;
   logic [3:0]  cfg_shut = 4'b0000;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [29:0] req_addr = '0;
   logic        resp_valid;
   logic [31:0] resp_data;
   logic        resp_miss;
   logic        mem_req;
   logic [29:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;
   int beats  = 0;
   logic [29:0] cur_line = '0;

   typedef struct {
      logic [31:0] data;
      logic        miss;
      string       rq;
   } exp_t;
   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   wcc_cache uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
      .cfg_shut(cfg_shut), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .resp_valid(resp_valid), .resp_data(resp_data),
      .resp_miss(resp_miss), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   function automatic logic [31:0] memfn(input logic [29:0] a);
      return ({2'b00, a} * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
   endfunction

   // tag-high bits [29:11], way-select [10:9], index [8:3], word [2:0]
   function automatic logic [29:0] mk(input int hi, input int sel, input int idx, input int wd);
      return (30'(hi) << 11) | (30'(sel) << 9) | (30'(idx) << 3) | 30'(wd);
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   // memory model: returns eight words per transfer with gaps, checks beat addresses
   initial begin
      int mb;
      int gap;
      mb = 0;
      gap = 1;
      forever begin
         @(negedge clk);
         if (mem_rvalid) begin
            mem_rvalid = 1'b0;
            mb = (mb == 7) ? 0 : mb + 1;
         end else if (mem_req) begin
            if (gap > 0) gap--;
            else begin
               chk(mem_addr == cur_line + 30'(mb), "R7", "beat address",
                   32'(mem_addr), 32'(cur_line + 30'(mb)));
               mem_rdata  = memfn(mem_addr);
               mem_rvalid = 1'b1;
               beats++;
               gap = beats % 3;
            end
         end
      end
   end

   // monitor: compares responses in order against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (resp_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R11", "unexpected response", 32'(resp_data), 32'h0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(resp_data == e.data, e.rq, "resp_data", resp_data, e.data);
               chk(resp_miss == e.miss, e.rq, "resp_miss", 32'(resp_miss), 32'(e.miss));
            end
         end
      end
   end

   task automatic access(input logic [29:0] a, input bit miss, input string rq);
      int b0;
      b0 = beats;
      exp_q.push_back('{memfn(a), miss, rq});
      cur_line = {a[29:3], 3'b000};
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      wait (exp_q.size() == 0);
      @(negedge clk);
      chk((beats - b0) == (miss ? 8 : 0), rq, "memory beats",
          32'(beats - b0), miss ? 32'd8 : 32'd0);
   endtask

   task automatic set_cfg(input logic [1:0] m, input logic [3:0] s);
      @(negedge clk);
      cfg_we = 1'b1; cfg_mode = m; cfg_shut = s;
      #1;
      chk(req_ready == 1'b0, "R9", "req_ready during cfg_we", 32'(req_ready), 32'd0);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic finish_up;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      chk(1'b0, "R11", "watchdog expired", 32'd0, 32'd1);
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'd1);
      chk(resp_valid == 1'b0, "R1", "resp_valid after reset", 32'(resp_valid), 32'd0);
      chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 32'd0);
      access(mk(0, 0, 3, 5), 1'b1, "R1");
      // R7 other words of the filled line hit
      access(mk(0, 0, 3, 0), 1'b0, "R7");
      access(mk(0, 0, 3, 7), 1'b0, "R7");

      // R11 hit latency: LOOK cycle without response, then one pulse
      exp_q.push_back('{memfn(mk(0, 0, 3, 2)), 1'b0, "R11"});
      @(negedge clk);
      req_valid = 1'b1; req_addr = mk(0, 0, 3, 2);
      @(negedge clk);
      req_valid = 1'b0;
      chk(resp_valid == 1'b0, "R11", "resp in lookup cycle", 32'(resp_valid), 32'd0);
      @(negedge clk);
      chk(resp_valid == 1'b1, "R11", "resp one cycle later", 32'(resp_valid), 32'd1);
      @(negedge clk);
      chk(resp_valid == 1'b0, "R11", "resp pulse width", 32'(resp_valid), 32'd0);

      // R2 four-way: four tags in set 7, all retained
      for (int h = 1; h <= 4; h++) access(mk(h, 0, 7, 1), 1'b1, "R2");
      for (int h = 1; h <= 4; h++) access(mk(h, 0, 7, 1), 1'b0, "R2");
      // R8 fifth tag evicts way 0 (tag 1); pointer then at way 1
      access(mk(5, 0, 7, 1), 1'b1, "R8");
      access(mk(3, 0, 7, 1), 1'b0, "R8");
      access(mk(1, 0, 7, 1), 1'b1, "R8");
      access(mk(5, 0, 7, 1), 1'b0, "R8");
      access(mk(2, 0, 7, 1), 1'b1, "R8");

      // R9 config write invalidates all lines
      set_cfg(2'b11, 4'b0000);
      access(mk(3, 0, 7, 1), 1'b1, "R9");

      // R3 direct-mapped
      set_cfg(2'b00, 4'b0000);
      for (int s = 0; s < 4; s++) access(mk(1, s, 9, 4), 1'b1, "R3");
      for (int s = 0; s < 4; s++) access(mk(1, s, 9, 4), 1'b0, "R3");
      access(mk(2, 0, 9, 4), 1'b1, "R3");
      access(mk(1, 0, 9, 4), 1'b1, "R3");
      access(mk(1, 1, 9, 4), 1'b0, "R3");

      // R4 two-way, mode 01
      set_cfg(2'b01, 4'b0000);
      access(mk(1, 0, 11, 6), 1'b1, "R4");
      access(mk(1, 1, 11, 6), 1'b1, "R4");
      access(mk(2, 2, 11, 6), 1'b1, "R4");
      access(mk(3, 0, 11, 6), 1'b1, "R4");
      access(mk(1, 1, 11, 6), 1'b0, "R4");
      access(mk(2, 2, 11, 6), 1'b0, "R4");
      access(mk(3, 0, 11, 6), 1'b0, "R4");
      access(mk(1, 0, 11, 6), 1'b1, "R4");
      // R4 two-way, mode 10
      set_cfg(2'b10, 4'b0000);
      access(mk(1, 0, 12, 0), 1'b1, "R4");
      access(mk(1, 0, 12, 0), 1'b0, "R4");
      access(mk(1, 1, 12, 0), 1'b1, "R4");
      access(mk(1, 0, 12, 0), 1'b0, "R4");

      // R5 four-way with ways 0 and 1 shut
      set_cfg(2'b11, 4'b0011);
      access(mk(1, 0, 13, 3), 1'b1, "R5");
      access(mk(2, 0, 13, 3), 1'b1, "R5");
      access(mk(3, 0, 13, 3), 1'b1, "R5");
      access(mk(2, 0, 13, 3), 1'b0, "R5");
      access(mk(3, 0, 13, 3), 1'b0, "R5");
      access(mk(1, 0, 13, 3), 1'b1, "R5");

      // R6 direct-mapped with way 0 shut: sel 0 has no way
      set_cfg(2'b00, 4'b0001);
      access(mk(4, 0, 20, 2), 1'b1, "R6");
      access(mk(4, 0, 20, 2), 1'b1, "R6");
      access(mk(4, 1, 20, 2), 1'b1, "R6");
      access(mk(4, 1, 20, 2), 1'b0, "R6");

      // R10 cfg_we during a refill is ignored
      set_cfg(2'b11, 4'b0000);
      fork
         access(mk(6, 0, 30, 1), 1'b1, "R10");
         begin
            wait (mem_req == 1'b1);
            @(negedge clk);
            cfg_we = 1'b1; cfg_mode = 2'b00; cfg_shut = 4'b1111;
            #1;
            chk(req_ready == 1'b0, "R10", "req_ready while busy", 32'(req_ready), 32'd0);
            @(negedge clk);
            cfg_we = 1'b0;
         end
      join
      access(mk(6, 0, 30, 1), 1'b0, "R10");
      access(mk(7, 1, 30, 1), 1'b1, "R10");
      access(mk(7, 1, 30, 1), 1'b0, "R10");
      access(mk(6, 0, 30, 1), 1'b0, "R10");

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R11", "responses outstanding", 32'(exp_q.size()), 32'd0);
      finish_up();
   end

endmodule